// File: doc/BRIEF.md
# Peripheral Window Address Decoder

This block sits between a CPU-side bus and a group of memory-mapped peripherals placed in one fixed address window. For each request it works out which configured region the address falls in and whether the requested access width is allowed there. It returns a one-hot select, the region index, the byte offset inside that region, a hit flag and an error flag. The bus handshake and the peripherals are handled elsewhere. The decoder only classifies one request per cycle.

The region table is set entirely by parameters. Each region has an offset from the window base, a size in bytes and a three-bit mask of allowed widths. The absolute start of a region is the window base plus its offset, and the window spans `WIN_SIZE` bytes. Matching is combinational. The result is registered once, so it appears one clock after the request is accepted.

A two-state controller tracks whether a registered result is on the outputs. `ST_IDLE` means no result is held. `ST_RESP` means a result is held. The transitions are:
- `ST_IDLE` goes to `ST_RESP` on `req_valid`.
- `ST_RESP` stays in `ST_RESP` while `req_valid` remains high, loading a new result each cycle.
- `ST_RESP` returns to `ST_IDLE` when `req_valid` is low.

Top module: `win_decoder`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, `rsp_valid`, `rsp_sel`, `rsp_idx`, `rsp_ofs`, `rsp_hit` and `rsp_err` are all zero.
- R2: A request presented with `req_valid` high at a rising edge produces `rsp_valid` high after that edge, for one cycle per accepted request. A cycle with `req_valid` low leaves every response output at zero after the next edge.
- R3: An address inside region i with a permitted width gives `rsp_hit`=1, `rsp_err`=0, `rsp_sel` with only bit i set, and `rsp_idx`=i. Region i covers `WIN_BASE`+offset up to, but not including, `WIN_BASE`+offset+size.
- R4: On a hit, `rsp_ofs` equals the request address minus the absolute start of the matched region.
- R5: An address that lies in no region gives `rsp_hit`=0, `rsp_err`=1, `rsp_sel`=0, `rsp_idx`=0 and `rsp_ofs`=0.
- R6: `req_size` is encoded as 00 = byte, 01 = halfword, 10 = word, and 11 = reserved. Width mask bit 0 allows byte, bit 1 allows halfword and bit 2 allows word. If the matched region's mask lacks the requested width bit, or the size is reserved, the result is `rsp_hit`=1, `rsp_err`=1 and `rsp_sel`=0. `rsp_idx` and `rsp_ofs` still report the matched region.
- R7: Consecutive cycles with `req_valid` high each produce their own result on the following cycle, with no gap.
- R8: Addresses below `WIN_BASE`, or at or above `WIN_BASE`+`WIN_SIZE`, never match any region.
- R9: Where regions overlap, the lowest-numbered region containing the address is chosen. The width check is then made against that region only.
- R10: The last byte of a region matches it, and the first byte past its end does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 2 | Access width code |
| rsp_valid | output | 1 | Registered result present |
| rsp_sel | output | N_REG | One-hot region select, zero on any error |
| rsp_idx | output | IDX_W | Index of matched region |
| rsp_ofs | output | OFS_W | Byte offset inside the matched region |
| rsp_hit | output | 1 | Address fell in a region |
| rsp_err | output | 1 | Miss or width not permitted |

## Verification
Every response field is due exactly one rising edge after the request that caused it. An idle cycle clears the fields after one edge, and reset clears them immediately. The bench drives inputs on the falling edge. At the next falling edge, half a period after the sampling edge, it compares all outputs with the result its model computed for the inputs just driven. Each cycle's expectation is therefore matched against exactly the cycle the design should answer in, including back-to-back requests and the cycle that follows a dropped `req_valid`.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } dec_state_e;

    localparam int WMASK_W = 3;

endpackage

// File: rtl/win_region_match.sv
module win_region_match #(
    parameter int              OFS_W    = 20,
    parameter logic [OFS_W-1:0] R_OFS   = '0,
    parameter logic [OFS_W-1:0] R_SIZE  = '0
) (
    input  logic             in_win,
    input  logic [OFS_W-1:0] rel,
    output logic             hit,
    output logic [OFS_W-1:0] local_ofs
);
    logic [OFS_W-1:0] diff;

    always_comb begin
        diff      = rel - R_OFS;
        hit       = in_win && (rel >= R_OFS) && (diff < R_SIZE);
        local_ofs = diff;
    end
endmodule

// File: rtl/win_prio_pick.sv
module win_prio_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/win_decoder.sv
module win_decoder
    import win_dec_pkg::*;
#(
    parameter int                       ADDR_W    = 32,
    parameter int                       OFS_W     = 20,
    parameter int                       N_REG     = 4,
    parameter logic [ADDR_W-1:0]        WIN_BASE  = 32'h4800_0000,
    parameter logic [ADDR_W-1:0]        WIN_SIZE  = 32'h000B_4000,
    parameter logic [N_REG*OFS_W-1:0]   REG_OFS   = {20'h41800, 20'hB3000, 20'h41000, 20'h40800},
    parameter logic [N_REG*OFS_W-1:0]   REG_SIZE  = {20'h01000, 20'h01000, 20'h01000, 20'h00800},
    parameter logic [N_REG*WMASK_W-1:0] REG_WMASK = {3'b011, 3'b111, 3'b100, 3'b100},
    localparam int                      IDX_W     = (N_REG > 1) ? $clog2(N_REG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              rsp_valid,
    output logic [N_REG-1:0]  rsp_sel,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [OFS_W-1:0]  rsp_ofs,
    output logic              rsp_hit,
    output logic              rsp_err
);
    dec_state_e state_q, state_d;

    logic [ADDR_W-1:0] win_rel;
    logic              in_win;
    logic [OFS_W-1:0]  rel;
    logic [N_REG-1:0]  hits;
    logic [OFS_W-1:0]  ofs_vec [N_REG];
    logic              any_hit;
    logic [IDX_W-1:0]  pick;
    logic [WMASK_W-1:0] wm;
    logic              width_ok;

    logic              nx_hit, nx_err;
    logic [N_REG-1:0]  nx_sel;
    logic [IDX_W-1:0]  nx_idx;
    logic [OFS_W-1:0]  nx_ofs;

    always_comb begin
        win_rel = req_addr - WIN_BASE;
        in_win  = win_rel < WIN_SIZE;
        rel     = win_rel[OFS_W-1:0];
    end

    for (genvar g = 0; g < N_REG; g++) begin : g_region
        win_region_match #(
            .OFS_W  (OFS_W),
            .R_OFS  (REG_OFS [g*OFS_W +: OFS_W]),
            .R_SIZE (REG_SIZE[g*OFS_W +: OFS_W])
        ) u_match (
            .in_win    (in_win),
            .rel       (rel),
            .hit       (hits[g]),
            .local_ofs (ofs_vec[g])
        );
    end

    win_prio_pick #(
        .N     (N_REG),
        .IDX_W (IDX_W)
    ) u_pick (
        .hits (hits),
        .any  (any_hit),
        .idx  (pick)
    );

    always_comb begin
        wm       = REG_WMASK[pick*WMASK_W +: WMASK_W];
        width_ok = (req_size != SZ_RSVD) && wm[req_size];
        nx_hit   = any_hit;
        nx_err   = !any_hit || !width_ok;
        nx_sel   = (any_hit && width_ok) ? (N_REG'(1) << pick) : '0;
        nx_idx   = any_hit ? pick : '0;
        nx_ofs   = any_hit ? ofs_vec[pick] : '0;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid)  state_d = ST_RESP;
            ST_RESP: if (!req_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_sel <= '0;
            rsp_idx <= '0;
            rsp_ofs <= '0;
            rsp_hit <= 1'b0;
            rsp_err <= 1'b0;
        end else if (state_d == ST_RESP) begin
            rsp_sel <= nx_sel;
            rsp_idx <= nx_idx;
            rsp_ofs <= nx_ofs;
            rsp_hit <= nx_hit;
            rsp_err <= nx_err;
        end else begin
            rsp_sel <= '0;
            rsp_idx <= '0;
            rsp_ofs <= '0;
            rsp_hit <= 1'b0;
            rsp_err <= 1'b0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);

    // R3: at most one region selected
    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_sel));

    // R3 and R6: a select implies a clean hit
    a_r6_sel_needs_clean_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_sel != '0) |-> (rsp_hit && !rsp_err));

    // R5: a miss always flags an error
    a_r5_miss_is_error: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_err && rsp_sel == '0));

    // R2 and R7: one result per accepted request
    a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_err && rsp_sel == '0));

    // R4: the offset stays inside the matched region
    a_r4_ofs_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_ofs < REG_SIZE[rsp_idx*OFS_W +: OFS_W]));

endmodule

// File: tb/win_decoder_tb.sv
module win_decoder_tb;

    localparam int ADDR_W = 32;
    localparam int OFS_W  = 20;
    localparam int N_REG  = 4;
    localparam int IDX_W  = 2;
    localparam longint BASE = 64'h4800_0000;
    localparam longint WSZ  = 64'h000B_4000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              rsp_valid;
    logic [N_REG-1:0]  rsp_sel;
    logic [IDX_W-1:0]  rsp_idx;
    logic [OFS_W-1:0]  rsp_ofs;
    logic              rsp_hit;
    logic              rsp_err;

    always #10 clk = ~clk;

    win_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .rsp_valid (rsp_valid),
        .rsp_sel   (rsp_sel),
        .rsp_idx   (rsp_idx),
        .rsp_ofs   (rsp_ofs),
        .rsp_hit   (rsp_hit),
        .rsp_err   (rsp_err)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    longint t_ofs  [N_REG] = '{64'h40800, 64'h41000, 64'hB3000, 64'h41800};
    longint t_size [N_REG] = '{64'h800,   64'h1000,  64'h1000,  64'h1000};
    int     t_mask [N_REG] = '{4, 4, 7, 3};

    logic             e_valid, e_hit, e_err;
    logic [N_REG-1:0] e_sel;
    longint           e_idx, e_ofs;
    string            e_tag;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic rst, input logic v, input longint a, input int sz);
        longint rel;
        int     m;
        e_valid = 1'b0; e_hit = 1'b0; e_err = 1'b0; e_sel = '0; e_idx = 0; e_ofs = 0;
        if (rst && v) begin
            e_valid = 1'b1;
            rel = a - BASE;
            m = -1;
            if (a >= BASE && rel < WSZ) begin
                for (int i = N_REG - 1; i >= 0; i--)
                    if (rel >= t_ofs[i] && rel < t_ofs[i] + t_size[i]) m = i;
            end
            if (m < 0) begin
                e_err = 1'b1;
            end else begin
                e_hit = 1'b1;
                e_idx = m;
                e_ofs = rel - t_ofs[m];
                if (sz != 3 && ((t_mask[m] >> sz) & 1) == 1) e_sel[m] = 1'b1;
                else e_err = 1'b1;
            end
        end
    endtask

    task automatic step(input logic rst, input logic v, input longint a, input int sz, input string tag);
        @(negedge clk);
        chk("R2", "valid", longint'(rsp_valid), longint'(e_valid));
        chk(e_tag, "hit", longint'(rsp_hit), longint'(e_hit));
        chk(e_tag, "err", longint'(rsp_err), longint'(e_err));
        chk(e_tag, "sel", longint'(rsp_sel), longint'(e_sel));
        chk(e_tag, "idx", longint'(rsp_idx), e_idx);
        chk(e_tag, "ofs", longint'(rsp_ofs), e_ofs);
        rst_n     = rst;
        req_valid = v;
        req_addr  = a[ADDR_W-1:0];
        req_size  = sz[1:0];
        model(rst, v, a, sz);
        e_tag = tag;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        model(1'b0, 1'b0, 0, 0);
        e_tag = "R1";
        // R1 reset
        repeat (3) step(1'b0, 1'b1, 64'h4804_0800, 2, "R1");
        step(1'b1, 1'b0, 64'h4804_0800, 2, "R1");
        // R2 idle cycles
        step(1'b1, 1'b0, 64'h4804_1000, 2, "R2");
        // R3 hits in each region, back-to-back for R7
        step(1'b1, 1'b1, 64'h4804_0800, 2, "R3");
        step(1'b1, 1'b1, 64'h4804_1004, 2, "R7");
        step(1'b1, 1'b1, 64'h480B_3001, 0, "R3");
        step(1'b1, 1'b1, 64'h480B_3002, 1, "R3");
        step(1'b1, 1'b0, 64'h480B_3002, 1, "R2");
        // R4 offsets
        step(1'b1, 1'b1, 64'h4804_0FFC, 2, "R4");
        step(1'b1, 1'b1, 64'h480B_3ABC, 2, "R4");
        // R10 boundaries
        step(1'b1, 1'b1, 64'h4804_0FFF, 2, "R10");
        step(1'b1, 1'b1, 64'h4804_07FF, 2, "R10");
        step(1'b1, 1'b1, 64'h4804_27FF, 0, "R10");
        step(1'b1, 1'b1, 64'h4804_2800, 0, "R10");
        // R5 misses
        step(1'b1, 1'b1, 64'h4800_0000, 2, "R5");
        step(1'b1, 1'b1, 64'h4805_0000, 0, "R5");
        // R6 width not permitted
        step(1'b1, 1'b1, 64'h4804_0800, 0, "R6");
        step(1'b1, 1'b1, 64'h4804_1010, 1, "R6");
        step(1'b1, 1'b1, 64'h480B_3000, 3, "R6");
        step(1'b1, 1'b1, 64'h4804_2000, 2, "R6");
        // R8 window limits
        step(1'b1, 1'b1, 64'h47FF_FFFF, 0, "R8");
        step(1'b1, 1'b1, 64'h480B_4000, 0, "R8");
        step(1'b1, 1'b1, 64'h4884_0800, 2, "R8");
        // R9 overlap priority
        step(1'b1, 1'b1, 64'h4804_1900, 2, "R9");
        step(1'b1, 1'b1, 64'h4804_1900, 0, "R9");
        step(1'b1, 1'b1, 64'h4804_2000, 0, "R9");
        step(1'b1, 1'b0, 64'h0, 0, "R2");
        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            longint a;
            a = BASE + longint'($urandom_range(32'h000B_8000, 32'h0003_F000));
            step(1'b1, ($urandom_range(3, 0) != 0), a, int'($urandom_range(3, 0)), "R3");
        end
        step(1'b1, 1'b0, 64'h0, 0, "R2");
        step(1'b1, 1'b0, 64'h0, 0, "R2");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule